// File: doc/BRIEF.md
# Three-Wire Serial Time Access Port

This block sits between a calendar counter bank and three input pins (chip enable, write select and serial clock) plus a bidirectional data pin. A host frames each transfer with chip enable. While enable is high, the level of write select at the start of the frame picks either a read or a write.

A read freezes a 52-bit image of the counters on the first rising serial clock and returns it one bit per rising edge. A write collects 52 bits and hands them to the counters as one word. During a write the block also pulses a divider reset and holds a carry inhibit, which keep the seconds chain from advancing while the new time goes in.

The block runs entirely on a system clock. Every pin passes through a two-flop synchronizer, and the serial clock is edge-detected after synchronization. The bidirectional pin is represented as a data output plus an output enable; the pad logic outside the block turns these into a tristate driver. Chip enable must be high for a few system cycles before the first serial clock edge.

Top module: `stp_port`

## Requirements
- R1: With chip enable high, the write-select level seen when the frame opens sets the mode for the whole frame. Low selects read, and `sdo_oe` is high for the whole frame. High selects write, and `sdo_oe` stays low.
- R2: While the synchronized chip enable is low, the following hold. `sdo_oe`, `sdo` and `carry_hold_o` are 0. `test_clr_o` is 1. Serial clock, data and write-select activity produce no commit, divider-reset or flag pulse.
- R3: In a read, the first rising serial clock loads `snap_i` and drives bit 0 on `sdo`. The k-th rising edge drives bit k-1. Changes to `snap_i` after the first edge do not alter the bits returned.
- R4: The 52-bit image has the following fields, each sent LSB first: seconds in [7:0] (bit 7 carries the low-supply flag), minutes in [15:8], hours in [23:16], weekday in [27:24], day in [35:28], month in [43:36] and year in [51:44]. A read cut short after 28 edges returns bits 0 through 27, that is, seconds through weekday.
- R5: After the 52nd rising edge of a read, `sdo` keeps bit 51 however many further edges arrive.
- R6: `flag_clr_o` pulses for exactly one cycle when a read reaches its 52nd edge. A read shorter than 52 edges produces no pulse.
- R7: In a write, each rising serial clock samples the data pin. The first sampled bit becomes bit 0 of the word.
- R8: After the 52nd written bit, `commit_o` pulses for one cycle while `commit_data_o` holds the 52 sampled bits. Edges 53 and later neither shift data nor commit.
- R9: A write whose chip enable drops before 52 bits produces no commit.
- R10: In a write, the first falling serial clock edge gives one `div_rst_o` pulse and raises `carry_hold_o`. `carry_hold_o` stays high until chip enable is seen low. A read produces neither.
- R11: When the drop of chip enable and the 52nd rising edge are seen in the same system cycle, the drop wins and no commit occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_pin | input | 1 | Chip enable pin, asynchronous |
| wsel_pin | input | 1 | Write-select pin, asynchronous |
| sclk_pin | input | 1 | Serial clock pin, asynchronous |
| sdi_pin | input | 1 | Data pin input path, asynchronous |
| snap_i | input | 52 | Live counter image presented by the calendar |
| sdo | output | 1 | Data pin output path |
| sdo_oe | output | 1 | Output enable for the data pin |
| commit_o | output | 1 | One-cycle pulse: load `commit_data_o` into the counters |
| commit_data_o | output | 52 | Assembled write word |
| div_rst_o | output | 1 | One-cycle sub-second divider reset |
| carry_hold_o | output | 1 | Inhibit of the carry into seconds |
| flag_clr_o | output | 1 | One-cycle clear of the low-supply flag |
| test_clr_o | output | 1 | High while chip enable is low; clears the test bit |

## Verification
Two events can collide in a single system cycle: the 52nd rising serial edge, which would commit the write, and the release of chip enable, which closes the frame. The bench provokes this by changing both pins at the same instant. Both pass through identical synchronizers, so they reach the control logic together. The bench expects no commit pulse, and its cycle-accurate model, which gives the close of the frame priority, must agree with the outputs on every clock.

// File: rtl/stp_pkg.sv
package stp_pkg;

    localparam int FRAME_BITS = 52;

    typedef enum logic {
        XFER_READ  = 1'b0,
        XFER_WRITE = 1'b1
    } xfer_mode_e;

    typedef enum logic [1:0] {
        SH_HOLD,
        SH_LOAD,
        SH_SHIFT_OUT,
        SH_SHIFT_IN
    } sh_op_e;

    typedef struct packed {
        logic ce;
        logic wsel;
        logic sclk;
        logic sdi;
    } pin_bus_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } sclk_evt_t;

    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/stp_sync.sv
module stp_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '0;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/stp_ctrl.sv
module stp_ctrl
    import stp_pkg::*;
#(
    parameter int BITS = FRAME_BITS
) (
    input  logic      clk,
    input  logic      rst,
    input  pin_bus_t  pins,
    output sclk_evt_t evt,
    output sh_op_e    sh_op,
    output logic      oe,
    output logic      div_rst,
    output logic      carry_hold,
    output logic      flag_clr,
    output logic      commit,
    output logic      test_clr
);
    localparam int CW = cnt_width(BITS);
    localparam logic [CW-1:0] LAST = CW'(BITS - 1);
    localparam logic [CW-1:0] FULL = CW'(BITS);

    logic          sclk_q;
    logic          active;
    xfer_mode_e    mode;
    logic [CW-1:0] cnt;
    logic          take_edge;

    assign evt.rise  = pins.sclk & ~sclk_q;
    assign evt.fall  = ~pins.sclk & sclk_q;
    assign take_edge = pins.ce & active & evt.rise & (cnt < FULL);

    // Operation handed to the shift register for this cycle
    always_comb begin
        sh_op = SH_HOLD;
        if (take_edge) begin
            if (mode == XFER_WRITE)   sh_op = SH_SHIFT_IN;
            else if (cnt == '0)       sh_op = SH_LOAD;
            else                      sh_op = SH_SHIFT_OUT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q     <= 1'b0;
            active     <= 1'b0;
            mode       <= XFER_READ;
            cnt        <= '0;
            div_rst    <= 1'b0;
            carry_hold <= 1'b0;
            flag_clr   <= 1'b0;
            commit     <= 1'b0;
        end else begin
            sclk_q   <= pins.sclk;
            div_rst  <= 1'b0;
            flag_clr <= 1'b0;
            commit   <= 1'b0;
            if (!pins.ce) begin
                // frame closed: release has priority over any edge
                active     <= 1'b0;
                cnt        <= '0;
                carry_hold <= 1'b0;
            end else if (!active) begin
                active <= 1'b1;
                mode   <= xfer_mode_e'(pins.wsel);
                cnt    <= '0;
            end else begin
                if (evt.fall && mode == XFER_WRITE && cnt == CW'(1) && !carry_hold) begin
                    div_rst    <= 1'b1;
                    carry_hold <= 1'b1;
                end
                if (take_edge) begin
                    cnt <= cnt + CW'(1);
                    if (cnt == LAST) begin
                        if (mode == XFER_WRITE) commit   <= 1'b1;
                        else                    flag_clr <= 1'b1;
                    end
                end
            end
        end
    end

    assign oe       = active & (mode == XFER_READ);
    assign test_clr = ~active;
endmodule

// File: rtl/stp_shreg.sv
module stp_shreg
    import stp_pkg::*;
#(
    parameter int BITS = FRAME_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  sh_op_e          op,
    input  logic [BITS-1:0] snap,
    input  logic            sdi,
    input  logic            oe,
    output logic [BITS-1:0] q,
    output logic            sdo
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (op)
                SH_LOAD:      q <= snap;
                SH_SHIFT_OUT: q <= {1'b0, q[BITS-1:1]};
                SH_SHIFT_IN:  q <= {sdi, q[BITS-1:1]};
                default:      q <= q;
            endcase
        end
    end

    assign sdo = oe & q[0];
endmodule

// File: rtl/stp_port.sv
module stp_port
    import stp_pkg::*;
#(
    parameter int BITS        = FRAME_BITS,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ce_pin,
    input  logic            wsel_pin,
    input  logic            sclk_pin,
    input  logic            sdi_pin,
    input  logic [BITS-1:0] snap_i,
    output logic            sdo,
    output logic            sdo_oe,
    output logic            commit_o,
    output logic [BITS-1:0] commit_data_o,
    output logic            div_rst_o,
    output logic            carry_hold_o,
    output logic            flag_clr_o,
    output logic            test_clr_o
);
    localparam int PW = $bits(pin_bus_t);

    pin_bus_t  pins_raw;
    pin_bus_t  pins_s;
    logic      ce_s;
    sclk_evt_t evt;
    sh_op_e    sh_op;

    assign pins_raw = '{ce: ce_pin, wsel: wsel_pin, sclk: sclk_pin, sdi: sdi_pin};
    assign ce_s     = pins_s.ce;

    stp_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    stp_ctrl #(.BITS(BITS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .pins       (pins_s),
        .evt        (evt),
        .sh_op      (sh_op),
        .oe         (sdo_oe),
        .div_rst    (div_rst_o),
        .carry_hold (carry_hold_o),
        .flag_clr   (flag_clr_o),
        .commit     (commit_o),
        .test_clr   (test_clr_o)
    );

    stp_shreg #(.BITS(BITS)) u_shreg (
        .clk  (clk),
        .rst  (rst),
        .op   (sh_op),
        .snap (snap_i),
        .sdi  (pins_s.sdi),
        .oe   (sdo_oe),
        .q    (commit_data_o),
        .sdo  (sdo)
    );
endmodule

// File: rtl/stp_port_chk.sv
module stp_port_chk (
    input logic clk,
    input logic rst,
    input logic ce_s,
    input logic sclk_rise,
    input logic sdo,
    input logic sdo_oe,
    input logic commit,
    input logic flag_clr,
    input logic div_rst,
    input logic carry_hold
);
    // R2
    ce_low_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !ce_s |=> (!sdo_oe && !carry_hold));

    // R8
    commit_single_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);

    // R6
    flag_in_read_chk: assert property (@(posedge clk) disable iff (rst)
        flag_clr |-> sdo_oe);

    // R1
    commit_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        commit |-> !sdo_oe);

    // R10
    hold_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (carry_hold && ce_s) |=> carry_hold);

    // R5
    sdo_moves_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe && $past(sdo_oe) && !$past(sclk_rise)) |-> $stable(sdo));

    // R10
    pulses_apart_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({commit, flag_clr, div_rst}));
endmodule

bind stp_port stp_port_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ce_s       (ce_s),
    .sclk_rise  (evt.rise),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe),
    .commit     (commit_o),
    .flag_clr   (flag_clr_o),
    .div_rst    (div_rst_o),
    .carry_hold (carry_hold_o)
);

// File: tb/stp_port_tb_top.sv
`timescale 1ns/1ps
module stp_port_tb_top;
    localparam int NB = 52;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_pin = 0, wsel_pin = 0, sclk_pin = 0, sdi_pin = 0;
    logic [NB-1:0] snap_i = '0;
    logic sdo, sdo_oe, commit_o, div_rst_o, carry_hold_o, flag_clr_o, test_clr_o;
    logic [NB-1:0] commit_data_o;

    always #2.5 clk = ~clk;

    stp_port dut_i (
        .clk(clk), .rst(rst), .ce_pin(ce_pin), .wsel_pin(wsel_pin),
        .sclk_pin(sclk_pin), .sdi_pin(sdi_pin), .snap_i(snap_i),
        .sdo(sdo), .sdo_oe(sdo_oe), .commit_o(commit_o),
        .commit_data_o(commit_data_o), .div_rst_o(div_rst_o),
        .carry_hold_o(carry_hold_o), .flag_clr_o(flag_clr_o),
        .test_clr_o(test_clr_o)
    );

    int tests = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // ---------------- behavioural reference model ----------------
    bit [2:0] hce, hws, hsc, hsd;   // [0] newest pin sample
    int       m_n;
    bit       m_act, m_wr, m_hold, m_div, m_flag, m_com, m_rise, m_fall;
    logic [NB-1:0] m_word;

    always @(posedge clk) begin
        if (rst) begin
            hce = 0; hws = 0; hsc = 0; hsd = 0;
            m_n = 0; m_act = 0; m_wr = 0; m_hold = 0;
            m_div = 0; m_flag = 0; m_com = 0; m_word = '0;
        end else begin
            m_div = 0; m_flag = 0; m_com = 0;
            m_rise = hsc[1] && !hsc[2];
            m_fall = !hsc[1] && hsc[2];
            if (!hce[1]) begin
                m_act = 0; m_n = 0; m_hold = 0;
            end else if (!m_act) begin
                m_act = 1; m_wr = hws[1]; m_n = 0;
            end else begin
                if (m_fall && m_wr && m_n == 1 && !m_hold) begin
                    m_div = 1; m_hold = 1;
                end
                if (m_rise && m_n < NB) begin
                    if (m_wr) begin
                        m_word = {hsd[1], m_word[NB-1:1]};
                        if (m_n == NB-1) m_com = 1;
                    end else begin
                        m_word = (m_n == 0) ? snap_i : (m_word >> 1);
                        if (m_n == NB-1) m_flag = 1;
                    end
                    m_n++;
                end
            end
            hce = {hce[1:0], ce_pin};
            hws = {hws[1:0], wsel_pin};
            hsc = {hsc[1:0], sclk_pin};
            hsd = {hsd[1:0], sdi_pin};
        end
    end

    // per-cycle comparison and event counters
    int n_commit = 0, n_flag = 0, n_div = 0;
    logic [NB-1:0] last_commit = '0;

    always @(negedge clk) begin
        if (!rst) begin
            chk(sdo_oe == (m_act && !m_wr), "R1 oe", 64'(sdo_oe), 64'(m_act && !m_wr));
            chk(sdo == (m_act && !m_wr && m_word[0]), "R3 sdo", 64'(sdo), 64'(m_act && !m_wr && m_word[0]));
            chk(test_clr_o == !m_act, "R2 test_clr", 64'(test_clr_o), 64'(!m_act));
            chk(commit_o == m_com, "R8 commit", 64'(commit_o), 64'(m_com));
            chk(flag_clr_o == m_flag, "R6 flag_clr", 64'(flag_clr_o), 64'(m_flag));
            chk(div_rst_o == m_div, "R10 div_rst", 64'(div_rst_o), 64'(m_div));
            chk(carry_hold_o == m_hold, "R10 carry_hold", 64'(carry_hold_o), 64'(m_hold));
            if (m_com)
                chk(commit_data_o == m_word, "R7 commit_data", 64'(commit_data_o), 64'(m_word));
            if (commit_o) begin n_commit++; last_commit = commit_data_o; end
            if (flag_clr_o) n_flag++;
            if (div_rst_o) n_div++;
        end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(input int n, input logic [NB-1:0] img, output logic [NB-1:0] got);
        got = '0;
        snap_i = img; wsel_pin = 0; ce_pin = 1;
        wait_n(6);
        for (int i = 0; i < n; i++) begin
            sclk_pin = 1; wait_n(4);
            if (i < NB) got[i] = sdo;
            if (i == 0) snap_i = ~img;      // snapshot must be frozen
            sclk_pin = 0; wait_n(4);
        end
    endtask

    task automatic do_write(input int n, input logic [NB-1:0] w);
        wsel_pin = 1; ce_pin = 1;
        wait_n(6);
        for (int i = 0; i < n; i++) begin
            sdi_pin = (i < NB) ? w[i] : i[0];
            wait_n(2);
            sclk_pin = 1; wait_n(4);
            sclk_pin = 0; wait_n(4);
        end
    endtask

    task automatic close_frame();
        ce_pin = 0; wsel_pin = 0; wait_n(6);
    endtask

    initial begin
        logic [NB-1:0] img, got, w;
        int c0, f0, d0;
        wait_n(4); rst = 0; wait_n(3);

        // reset state
        chk(sdo_oe == 0 && test_clr_o == 1 && carry_hold_o == 0, "R2 reset",
            64'({sdo_oe, test_clr_o, carry_hold_o}), 64'b010);

        // full read with extra edges
        img = 52'hA_5C3B_1F27_0E96;
        f0 = n_flag;
        ce_pin = 1; wsel_pin = 0; wait_n(6);
        chk(sdo_oe == 1, "R1 read oe", 64'(sdo_oe), 64'd1);
        ce_pin = 0; wait_n(6);
        do_read(60, img, got);
        chk(got == img, "R3 R4 read bits", 64'(got), 64'(img));
        chk(sdo == img[NB-1], "R5 hold last bit", 64'(sdo), 64'(img[NB-1]));
        chk(n_flag - f0 == 1, "R6 one flag pulse", 64'(n_flag - f0), 64'd1);
        close_frame();
        chk(sdo_oe == 0 && sdo == 0 && test_clr_o == 1, "R2 after close",
            64'({sdo_oe, sdo, test_clr_o}), 64'b001);

        // short read: seconds..weekday
        img = 52'h3_7E21_9A4C_D058;
        f0 = n_flag;
        do_read(28, img, got);
        chk(got[27:0] == img[27:0], "R4 short read", 64'(got[27:0]), 64'(img[27:0]));
        chk(n_flag == f0, "R6 no flag short", 64'(n_flag - f0), 64'd0);
        chk(n_div == 0 && carry_hold_o == 0, "R10 none in read", 64'(n_div), 64'd0);
        close_frame();

        // full write
        w = 52'h2_5917_3C08_4E12;
        c0 = n_commit; d0 = n_div;
        ce_pin = 1; wsel_pin = 1; wait_n(6);
        chk(sdo_oe == 0, "R1 write oe", 64'(sdo_oe), 64'd0);
        ce_pin = 0; wait_n(6);
        do_write(52, w);
        chk(n_commit - c0 == 1, "R8 one commit", 64'(n_commit - c0), 64'd1);
        chk(last_commit == w, "R7 R8 commit data", 64'(last_commit), 64'(w));
        chk(n_div - d0 == 1, "R10 one div pulse", 64'(n_div - d0), 64'd1);
        chk(carry_hold_o == 1, "R10 hold while ce", 64'(carry_hold_o), 64'd1);
        close_frame();
        chk(carry_hold_o == 0, "R10 hold released", 64'(carry_hold_o), 64'd0);

        // over-long write: bits past 52 ignored
        w = 52'hF_0123_4567_89AB;
        c0 = n_commit;
        do_write(61, w);
        chk(n_commit - c0 == 1, "R8 single commit long", 64'(n_commit - c0), 64'd1);
        chk(last_commit == w && commit_data_o == w, "R8 extra bits ignored", 64'(commit_data_o), 64'(w));
        close_frame();

        // aborted write
        c0 = n_commit;
        do_write(30, 52'h1_1111_2222_3333);
        close_frame();
        chk(n_commit == c0, "R9 no commit short", 64'(n_commit - c0), 64'd0);

        // activity with ce low
        c0 = n_commit; d0 = n_div; f0 = n_flag;
        wsel_pin = 1;
        for (int i = 0; i < 60; i++) begin
            sdi_pin = i[1]; sclk_pin = 1; wait_n(3); sclk_pin = 0; wait_n(3);
        end
        chk(n_commit == c0 && n_div == d0 && n_flag == f0 && sdo_oe == 0,
            "R2 ignored while ce low", 64'(n_commit - c0 + n_div - d0), 64'd0);
        wsel_pin = 0; wait_n(4);

        // ce drop coinciding with 52nd edge
        c0 = n_commit;
        do_write(51, 52'h7_ACE1_0BAD_F00D);
        sdi_pin = 1; wait_n(2);
        ce_pin = 0; sclk_pin = 1; wait_n(6);
        sclk_pin = 0; wait_n(6);
        chk(n_commit == c0, "R11 release wins", 64'(n_commit - c0), 64'd0);
        chk(carry_hold_o == 0, "R11 hold cleared", 64'(carry_hold_o), 64'd0);

        wait_n(4);
        finish_run();
    end
endmodule